// File: doc/BRIEF.md
# DMA Request Channel Router

This block sits between peripheral request lines and a bank of DMA channels. Each request input owns a small map entry. The entry says whether the input is routed at all and, if so, to which channel. Software programs the entries through a simple word-addressed configuration port. The block then follows every change on a routed request input and keeps one request-active level per channel.

A rising or falling request does more than update that level. The block emits single-cycle event pulses for the channel status logic: setting or clearing the request-after-stop flag, setting the end-of-receive flag, and a kick that wakes the transfer engine. The event pulses and the level are registered. They appear in the cycle after the request input was sampled.

Several request inputs may share a channel. When more than one of them changes in the same cycle, the change on the highest-numbered input decides the channel's new level. Arbitration between shared requests, the transfer engine and the status flag storage all live outside this block.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset every map entry reads as zero (unrouted), all `chan_active` bits are 0 and no event pulse is asserted.
- R2: Entry i for i < 64 sits at byte address 0x100 + 4·i, and entry i for 64 ≤ i < NUM_REQ sits at 0x1100 + 4·(i−64). A read returns the 8-bit entry on `cfg_rdata` with `cfg_rvalid` high one cycle later. A read of any other or non-word-aligned address returns 0. A write to such an address changes no entry.
- R3: Bit 7 of an entry is the valid flag and bits 4:0 hold the channel number. A write to a decoded entry with bit 7 set and a channel number ≥ NUM_CH leaves the entry unchanged and pulses `cfg_err` one cycle later.
- R4: A change on a request input whose entry has bit 7 clear produces no event pulse and leaves `chan_active` unchanged.
- R5: A routed request that rises while its channel is inactive pulses `ras_set` and `kick` for that channel in the next cycle, and sets its `chan_active` bit.
- R6: Every other routed request change pulses `ras_clr` for that channel. This covers a rise while the channel is active and any fall. A rise also pulses `kick`.
- R7: A routed request that falls while its channel is active pulses `eor_set` and clears `chan_active` for that channel.
- R8: When several routed inputs for one channel change in the same cycle, the highest-numbered one alone determines the events and the new level.
- R9: Events and levels of different channels are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Byte address of the map entry |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| cfg_err | output | 1 | Pulse for a rejected write (channel out of range) |
| req_in | input | NUM_REQ | Peripheral request levels, sampled every clock |
| chan_active | output | NUM_CH | Request-active level per channel |
| ras_set | output | NUM_CH | Set request-after-stop flag event |
| ras_clr | output | NUM_CH | Clear request-after-stop flag event |
| eor_set | output | NUM_CH | Set end-of-receive flag event |
| kick | output | NUM_CH | Wake pulse to the transfer engine |

## Verification
The assertions assume that `req_in` and the configuration strobes are synchronous to `clk` and stable around the sampling edge. They also assume that reset is held from time zero, so that the first reference to a previous cycle sees reset state. The bench drives every input on the falling edge. It issues at most one configuration access per cycle and programs channel numbers both inside and outside the legal range. Request toggles are confined to a few inputs per cycle, so that several inputs sharing a channel often change together.

// File: rtl/dma_map_pkg.sv
package dma_map_pkg;
  localparam int MAP_W       = 8;
  localparam int VLD_BIT     = 7;
  localparam int CH_FIELD_W  = 5;
  localparam int LOW_COUNT   = 64;
  localparam logic [15:0] LOW_BASE  = 16'h0100;
  localparam logic [15:0] HIGH_BASE = 16'h1100;

  function automatic logic entry_valid(input logic [MAP_W-1:0] e);
    return e[VLD_BIT];
  endfunction

  function automatic logic [CH_FIELD_W-1:0] entry_chan(input logic [MAP_W-1:0] e);
    return e[CH_FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/map_addr_dec.sv
module map_addr_dec
  import dma_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = $clog2(NUM_REQ),
  localparam int HIGH_N = NUM_REQ - LOW_COUNT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] lo_off;
  logic [ADDR_W-1:0] hi_off;

  assign lo_off = addr - ADDR_W'(LOW_BASE);
  assign hi_off = addr - ADDR_W'(HIGH_BASE);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= ADDR_W'(LOW_BASE) && lo_off < ADDR_W'(4 * LOW_COUNT)) begin
        hit = 1'b1;
        idx = IDX_W'(lo_off >> 2);
      end else if (HIGH_N > 0 && addr >= ADDR_W'(HIGH_BASE) &&
                   hi_off < ADDR_W'(4 * HIGH_N)) begin
        hit = 1'b1;
        idx = IDX_W'(LOW_COUNT) + IDX_W'(hi_off >> 2);
      end
    end
  end
endmodule

// File: rtl/map_regs.sv
module map_regs
  import dma_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic                     hit,
  input  logic [IDX_W-1:0]         idx,
  input  logic [MAP_W-1:0]         wdata,
  output logic [MAP_W-1:0]         rdata,
  output logic                     rvalid,
  output logic                     err,
  output logic [NUM_REQ*MAP_W-1:0] map_flat
);
  logic bad_chan;
  assign bad_chan = entry_valid(wdata) && (32'(entry_chan(wdata)) >= NUM_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_flat <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
      err      <= 1'b0;
    end else begin
      rvalid <= rd;
      err    <= wr && hit && bad_chan;
      if (rd) rdata <= hit ? map_flat[idx*MAP_W +: MAP_W] : '0;
      if (wr && hit && !bad_chan) map_flat[idx*MAP_W +: MAP_W] <= wdata;
    end
  end
endmodule

// File: rtl/req_evt.sv
module req_evt
  import dma_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_in,
  input  logic [NUM_REQ*MAP_W-1:0] map_flat,
  output logic [NUM_CH-1:0]        level,
  output logic [NUM_CH-1:0]        ras_set,
  output logic [NUM_CH-1:0]        ras_clr,
  output logic [NUM_CH-1:0]        eor_set,
  output logic [NUM_CH-1:0]        kick
);
  logic [NUM_REQ-1:0] req_q;
  logic [NUM_REQ-1:0] chg;
  logic [NUM_CH-1:0]  sel_hit;
  logic [NUM_CH-1:0]  sel_val;

  assign chg = req_in ^ req_q;

  // Later (higher-numbered) inputs overwrite earlier ones: highest index wins.
  always_comb begin
    sel_hit = '0;
    sel_val = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (chg[r] && entry_valid(map_flat[r*MAP_W +: MAP_W]) &&
            entry_chan(map_flat[r*MAP_W +: MAP_W]) == CH_FIELD_W'(c)) begin
          sel_hit[c] = 1'b1;
          sel_val[c] = req_in[r];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      level   <= '0;
      ras_set <= '0;
      ras_clr <= '0;
      eor_set <= '0;
      kick    <= '0;
    end else begin
      req_q   <= req_in;
      ras_set <= sel_hit & sel_val & ~level;
      ras_clr <= sel_hit & ~(sel_val & ~level);
      eor_set <= sel_hit & ~sel_val & level;
      kick    <= sel_hit & sel_val;
      level   <= (sel_hit & sel_val) | (~sel_hit & level);
    end
  end
endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
  import dma_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [MAP_W-1:0]   cfg_wdata,
  output logic [MAP_W-1:0]   cfg_rdata,
  output logic               cfg_rvalid,
  output logic               cfg_err,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  chan_active,
  output logic [NUM_CH-1:0]  ras_set,
  output logic [NUM_CH-1:0]  ras_clr,
  output logic [NUM_CH-1:0]  eor_set,
  output logic [NUM_CH-1:0]  kick
);
  localparam int IDX_W = $clog2(NUM_REQ);

  logic                     dec_hit;
  logic [IDX_W-1:0]         dec_idx;
  logic [NUM_REQ*MAP_W-1:0] map_flat;

  map_addr_dec #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_dec (
    .addr(cfg_addr), .hit(dec_hit), .idx(dec_idx)
  );

  map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .hit(dec_hit),
    .idx(dec_idx), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .rvalid(cfg_rvalid), .err(cfg_err), .map_flat(map_flat)
  );

  req_evt #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_evt (
    .clk(clk), .rst(rst), .req_in(req_in), .map_flat(map_flat),
    .level(chan_active), .ras_set(ras_set), .ras_clr(ras_clr),
    .eor_set(eor_set), .kick(kick)
  );
endmodule

// File: rtl/dma_req_mapper_chk.sv
module dma_req_mapper_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic              cfg_rvalid,
  input logic              cfg_err,
  input logic [NUM_CH-1:0] chan_active,
  input logic [NUM_CH-1:0] ras_set,
  input logic [NUM_CH-1:0] ras_clr,
  input logic [NUM_CH-1:0] eor_set,
  input logic [NUM_CH-1:0] kick
);
  AST_RVALID_FROM_RD: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid |-> $past(cfg_rd)); // R2
  AST_ERR_FROM_WR: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_wr)); // R3
  AST_RAS_SET_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (ras_set & ~chan_active) == '0); // R5
  AST_KICK_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (kick & ~chan_active) == '0); // R5
  AST_RISE_HAS_KICK: assert property (@(posedge clk) disable iff (rst)
    ((chan_active & ~$past(chan_active)) & ~kick) == '0); // R5
  AST_RAS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (ras_set & ras_clr) == '0); // R6
  AST_EOR_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    (eor_set & chan_active) == '0); // R7
  AST_FALL_HAS_EOR: assert property (@(posedge clk) disable iff (rst)
    ((~chan_active & $past(chan_active)) & ~eor_set) == '0); // R7
endmodule

bind dma_req_mapper dma_req_mapper_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_rvalid(cfg_rvalid), .cfg_err(cfg_err), .chan_active(chan_active),
  .ras_set(ras_set), .ras_clr(ras_clr), .eor_set(eor_set), .kick(kick)
);

// File: tb/test_dma_req_mapper.sv
module test_dma_req_mapper;
  localparam int NUM_REQ = 75;
  localparam int NUM_CH  = 16;
  localparam int ADDR_W  = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_wr = 1'b0;
  logic               cfg_rd = 1'b0;
  logic [ADDR_W-1:0]  cfg_addr = '0;
  logic [7:0]         cfg_wdata = '0;
  logic [7:0]         cfg_rdata;
  logic               cfg_rvalid;
  logic               cfg_err;
  logic [NUM_REQ-1:0] req_in = '0;
  logic [NUM_CH-1:0]  chan_active, ras_set, ras_clr, eor_set, kick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [7:0]         m_map [NUM_REQ];
  logic [NUM_REQ-1:0] m_req;
  logic [NUM_CH-1:0]  m_lvl;
  logic [NUM_CH-1:0]  e_rs, e_rc, e_eor, e_kick;
  logic               e_err, e_rv;
  logic [7:0]         e_rd;

  always #5 clk = ~clk;

  dma_req_mapper #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dma_req_mapper (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .cfg_err(cfg_err), .req_in(req_in), .chan_active(chan_active),
    .ras_set(ras_set), .ras_clr(ras_clr), .eor_set(eor_set), .kick(kick)
  );

  function automatic logic [15:0] addr_of(input int i);
    return (i < 64) ? 16'(16'h0100 + 4 * i) : 16'(16'h1100 + 4 * (i - 64));
  endfunction

  function automatic int idx_of(input logic [15:0] a);
    for (int i = 0; i < NUM_REQ; i++) if (addr_of(i) == a) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, predict, and compare after the next edge.
  task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                      input logic [7:0] d, input logic [NUM_REQ-1:0] rq);
    int  ix;
    logic hit, val;
    cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_wdata = d; req_in = rq;
    e_rs = '0; e_rc = '0; e_eor = '0; e_kick = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      hit = 1'b0; val = 1'b0;
      for (int r = 0; r < NUM_REQ; r++)
        if (m_req[r] != rq[r] && m_map[r][7] && int'(m_map[r][4:0]) == c) begin
          hit = 1'b1; val = rq[r];
        end
      if (hit) begin
        e_rs[c]   = val && !m_lvl[c];
        e_rc[c]   = !(val && !m_lvl[c]);
        e_eor[c]  = !val && m_lvl[c];
        e_kick[c] = val;
        m_lvl[c]  = val;
      end
    end
    m_req = rq;
    ix = idx_of(a);
    e_rv = rd;
    e_rd = (ix >= 0) ? m_map[ix] : 8'h00;
    e_err = 1'b0;
    if (wr && ix >= 0) begin
      if (d[7] && int'(d[4:0]) >= NUM_CH) e_err = 1'b1;
      else m_map[ix] = d;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    chk("R5 kick", 32'(kick), 32'(e_kick));
    chk("R5 ras_set", 32'(ras_set), 32'(e_rs));
    chk("R6 ras_clr", 32'(ras_clr), 32'(e_rc));
    chk("R7 eor_set", 32'(eor_set), 32'(e_eor));
    chk("R7 chan_active", 32'(chan_active), 32'(m_lvl));
    chk("R3 cfg_err", 32'(cfg_err), 32'(e_err));
    chk("R2 cfg_rvalid", 32'(cfg_rvalid), 32'(e_rv));
    if (e_rv) chk("R2 cfg_rdata", 32'(cfg_rdata), 32'(e_rd));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NUM_REQ-1:0] rq;
    int unsigned sd;
    sd = $urandom(32'h1234_5678);
    for (int i = 0; i < NUM_REQ; i++) m_map[i] = 8'h00;
    m_req = '0; m_lvl = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 chan_active", 32'(chan_active), 0);
    chk("R1 events", 32'(ras_set | ras_clr | eor_set | kick), 0);
    step(0, 1, addr_of(0), 0, '0);  chk("R1 entry0", 32'(cfg_rdata), 0);
    step(0, 1, addr_of(74), 0, '0); chk("R1 entry74", 32'(cfg_rdata), 0);
    // R2: both windows
    step(1, 0, 16'h010C, 8'h82, '0);
    step(1, 0, 16'h1118, 8'h82, '0);
    step(0, 1, 16'h010C, 0, '0); chk("R2 low window", 32'(cfg_rdata), 32'h82);
    step(0, 1, 16'h1118, 0, '0); chk("R2 high window", 32'(cfg_rdata), 32'h82);
    step(1, 0, 16'h0102, 8'h85, '0);
    step(0, 1, 16'h0100, 0, '0); chk("R2 unaligned write ignored", 32'(cfg_rdata), 0);
    step(0, 1, 16'h0101, 0, '0); chk("R2 unaligned read", 32'(cfg_rdata), 0);
    // R3: channel out of range
    step(1, 0, addr_of(5), 8'h9F, '0); chk("R3 err pulse", 32'(cfg_err), 1);
    step(0, 1, addr_of(5), 0, '0);     chk("R3 entry kept", 32'(cfg_rdata), 0);
    // R4: unmapped input toggles
    rq = '0; rq[5] = 1'b1;
    step(0, 0, 0, 0, rq);
    chk("R4 no events", 32'(ras_set | ras_clr | eor_set | kick), 0);
    chk("R4 no level", 32'(chan_active), 0);
    // R5: rise on idle channel 2
    rq[3] = 1'b1;
    step(0, 0, 0, 0, rq);
    chk("R5 set+kick", 32'({ras_set[2], kick[2], chan_active[2]}), 32'b111);
    // R6: rise while active
    rq[70] = 1'b1;
    step(0, 0, 0, 0, rq);
    chk("R6 clr on active rise", 32'({ras_set[2], ras_clr[2], kick[2]}), 32'b011);
    // R7: fall while active
    rq[3] = 1'b0;
    step(0, 0, 0, 0, rq);
    chk("R7 eor on fall", 32'({eor_set[2], ras_clr[2], chan_active[2]}), 32'b110);
    // R8: simultaneous: 3 rises, 70 falls, 70 decides
    rq[3] = 1'b1; rq[70] = 1'b0;
    step(0, 0, 0, 0, rq);
    chk("R8 highest wins", 32'({kick[2], ras_clr[2], chan_active[2], eor_set[2]}), 32'b0100);
    // R9: channel 7 independent
    step(1, 0, addr_of(10), 8'h87, rq);
    rq[10] = 1'b1;
    step(0, 0, 0, 0, rq);
    chk("R9 independent", 32'(chan_active), 32'h0080);
    // random phase
    for (int i = 0; i < NUM_REQ; i++)
      step(1, 0, addr_of(i), 8'(($urandom % 4 != 0) ? 8'h80 : 8'h00) | 8'($urandom % NUM_CH), rq);
    for (int n = 0; n < 4000; n++) begin
      logic w, rd;
      logic [15:0] a;
      logic [7:0]  d;
      int sel;
      for (int k = 0; k < int'($urandom % 4); k++) rq[$urandom % 24] ^= 1'b1;
      sel = int'($urandom % 8);
      w = (sel == 0); rd = (sel == 1);
      a = ($urandom % 10 == 0) ? 16'($urandom) : addr_of(int'($urandom % NUM_REQ));
      d = 8'(($urandom % 4 != 0) ? 8'h80 : 8'h00) | 8'($urandom % 20);
      step(w, rd, a, d, rq);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule